// File: doc/BRIEF.md
# Oversampled Asynchronous Serial Receiver

This block takes a serial input line, oversamples it with a strobe running at sixteen times the bit rate, and recovers asynchronous frames from it. A frame opens with a low start bit and closes with a high stop bit. The payload in between arrives least significant bit first. The receiver checks each candidate start bit at its midpoint, so that short low glitches are rejected. It then takes the payload bits at their centres and writes the result into a holding register. A full flag, three sticky error flags and an interrupt request go with that register.

Two framing modes are selectable. In normal mode the payload is seven data bits, optionally followed by a parity bit that is checked and not stored. In multiprocessor mode the payload is eight data bits followed by an address/data marker bit, which is captured and reported next to the byte. The consumer reads the byte and then pulses a read strobe, which empties the holding register. A separate clear strobe resets the error flags.

Top module: `async_rx_unit`

## Requirements
- R1: Reception takes place only while `rx_en` is high. Lowering `rx_en` abandons any frame in progress, and a frame sent while `rx_en` is low leaves `rx_full` at 0.
- R2: A low level on the line starts a candidate frame. The line is sampled again 8 sampling ticks later. If it is high at that point, the event is discarded and `rx_full` stays unchanged.
- R3: In normal mode (`mode_mp`=0) seven data bits are received LSB first into `rx_data[6:0]`. `rx_data[7]` and `rx_mark` read 0.
- R4: In normal mode with `par_en`=1 the eighth bit is parity. With `par_odd`=0 the seven data bits plus parity must hold an even number of ones, and with `par_odd`=1 an odd number. A mismatch sets `err_parity`.
- R5: In multiprocessor mode (`mode_mp`=1) eight data bits go to `rx_data[7:0]` and the ninth bit goes to `rx_mark`. No parity check is made in this mode.
- R6: After reset `rx_full`, all error flags, `rx_irq`, `rx_data` and `rx_mark` are 0. Each completed frame loads `rx_data` and `rx_mark` and sets `rx_full`.
- R7: If the stop bit is sampled low, `err_frame` is set. The frame's data is still loaded and `rx_full` is still set.
- R8: If a frame completes while `rx_full` is already set (and no read strobe arrives in that cycle), `err_overrun` is set and the new data replaces the old.
- R9: A one-cycle pulse on `rd_strobe` clears `rx_full` and leaves the error flags unchanged.
- R10: The error flags stay set until `err_clr` is pulsed. `err_clr` affects neither `rx_full` nor `rx_data`.
- R11: `rx_irq` is high exactly while `irq_en` and `rx_full` are both high.
- R12: All bit timing counts ticks of `samp_tick` and not clock cycles, so frames are received correctly when the strobe is high only one clock in three.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_en | input | 1 | Receive enable |
| mode_mp | input | 1 | 0 normal framing, 1 multiprocessor framing |
| par_en | input | 1 | Parity bit present in normal mode |
| par_odd | input | 1 | 0 even parity, 1 odd parity |
| irq_en | input | 1 | Receive interrupt enable |
| samp_tick | input | 1 | Sampling strobe at 16x bit rate, one clock wide |
| rxd | input | 1 | Serial input line, idle high |
| rd_strobe | input | 1 | Holding register has been read; clears full flag |
| err_clr | input | 1 | Clears all error flags |
| rx_data | output | 8 | Received byte |
| rx_mark | output | 1 | Address/data marker of last multiprocessor frame |
| rx_full | output | 1 | Holding register holds unread data |
| err_parity | output | 1 | Sticky parity error |
| err_frame | output | 1 | Sticky framing error |
| err_overrun | output | 1 | Sticky overrun error |
| rx_irq | output | 1 | Receive interrupt request |

## Verification
The assertions assume that `mode_mp`, `par_en` and `par_odd` are held steady for the whole of a frame, and that `rd_strobe` and `err_clr` are single-cycle pulses. The bench changes the mode inputs only while the line is idle between frames, and it raises the strobes for one clock at a falling edge. Every bit is driven for sixteen strobe periods, so each centre sample falls well inside its bit whatever the phase of the strobe.

// File: rtl/rxu_pkg.sv
package rxu_pkg;
   typedef enum logic [1:0] {
      RXS_IDLE = 2'd0,
      RXS_CONF = 2'd1,
      RXS_DATA = 2'd2,
      RXS_STOP = 2'd3
   } rxu_state_e;
endpackage

// File: rtl/rxu_sync.sv
module rxu_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 1) begin : g_bad_stages
      $error("rxu_sync: STAGES must be at least 1");
   end

   if (STAGES == 1) begin : g_single
      logic r;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) r <= 1'b1;
         else        r <= d;
      end
      assign q = r;
   end else begin : g_chain
      logic [STAGES-1:0] sh;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sh <= '1;
         else        sh <= {sh[STAGES-2:0], d};
      end
      assign q = sh[STAGES-1];
   end
endmodule

// File: rtl/rxu_bit_timer.sv
module rxu_bit_timer
   import rxu_pkg::*;
#(
   parameter int OVERSAMPLE = 16,
   parameter int NORM_W     = 7,
   parameter int MP_W       = 8,
   localparam int FRAME_W   = MP_W + 1,
   localparam int IDX_W     = $clog2(FRAME_W + 1),
   localparam int CNT_W     = $clog2(OVERSAMPLE)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rx_en,
   input  logic             tick,
   input  logic             line,
   input  logic             mode_mp,
   input  logic             par_en,
   output logic             frame_start,
   output logic             bit_vld,
   output logic             bit_val,
   output logic [IDX_W-1:0] bit_idx,
   output logic             frame_done,
   output logic             stop_val
);
   localparam int HALF = OVERSAMPLE / 2;

   if (OVERSAMPLE < 4 || (OVERSAMPLE % 2) != 0) begin : g_bad_os
      $error("rxu_bit_timer: OVERSAMPLE must be even and at least 4");
   end

   rxu_state_e       state;
   logic [CNT_W-1:0] cnt;
   logic [IDX_W-1:0] idx;
   logic [IDX_W-1:0] last_idx;

   always_comb begin
      if (mode_mp)     last_idx = IDX_W'(FRAME_W - 1);
      else if (par_en) last_idx = IDX_W'(NORM_W);
      else             last_idx = IDX_W'(NORM_W - 1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state       <= RXS_IDLE;
         cnt         <= '0;
         idx         <= '0;
         frame_start <= 1'b0;
         bit_vld     <= 1'b0;
         bit_val     <= 1'b0;
         bit_idx     <= '0;
         frame_done  <= 1'b0;
         stop_val    <= 1'b1;
      end else begin
         frame_start <= 1'b0;
         bit_vld     <= 1'b0;
         frame_done  <= 1'b0;
         if (!rx_en) begin
            state <= RXS_IDLE;
            cnt   <= '0;
         end else if (tick) begin
            case (state)
               RXS_IDLE: begin
                  if (!line) begin
                     state <= RXS_CONF;
                     cnt   <= '0;
                  end
               end
               RXS_CONF: begin
                  if (cnt == CNT_W'(HALF - 1)) begin
                     cnt <= '0;
                     if (!line) begin
                        state       <= RXS_DATA;
                        idx         <= '0;
                        frame_start <= 1'b1;
                     end else begin
                        state <= RXS_IDLE;
                     end
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               RXS_DATA: begin
                  if (cnt == CNT_W'(OVERSAMPLE - 1)) begin
                     cnt     <= '0;
                     bit_vld <= 1'b1;
                     bit_val <= line;
                     bit_idx <= idx;
                     if (idx == last_idx) state <= RXS_STOP;
                     else                 idx   <= idx + 1'b1;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               default: begin
                  if (cnt == CNT_W'(OVERSAMPLE - 1)) begin
                     cnt        <= '0;
                     frame_done <= 1'b1;
                     stop_val   <= line;
                     state      <= RXS_IDLE;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
            endcase
         end
      end
   end

   // R1: with the enable low the timer is back in idle one cycle later
   p_idle_when_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_en |=> (state == RXS_IDLE));

   // R6: completion is a single-cycle event
   p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |=> !frame_done);

   // R2: a confirmed start is always followed by the data phase
   p_start_to_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_start && rx_en) |-> (state == RXS_DATA));
endmodule

// File: rtl/rxu_frame_asm.sv
module rxu_frame_asm #(
   parameter int NORM_W   = 7,
   parameter int MP_W     = 8,
   localparam int FRAME_W = MP_W + 1,
   localparam int IDX_W   = $clog2(FRAME_W + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             frame_start,
   input  logic             bit_vld,
   input  logic             bit_val,
   input  logic [IDX_W-1:0] bit_idx,
   input  logic             mode_mp,
   input  logic             par_en,
   input  logic             par_odd,
   output logic [MP_W-1:0]  dec_data,
   output logic             dec_mark,
   output logic             dec_perr
);
   if (MP_W <= NORM_W || NORM_W < 1) begin : g_bad_widths
      $error("rxu_frame_asm: MP_W must exceed NORM_W, NORM_W at least 1");
   end

   logic [FRAME_W-1:0] bits;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bits <= '0;
      end else if (frame_start) begin
         bits <= '0;
      end else if (bit_vld) begin
         for (int i = 0; i < FRAME_W; i++) begin
            if (bit_idx == IDX_W'(i)) bits[i] <= bit_val;
         end
      end
   end

   logic par_calc;
   assign par_calc = (^bits[NORM_W-1:0]) ^ bits[NORM_W] ^ par_odd;

   always_comb begin
      if (mode_mp) begin
         dec_data = bits[MP_W-1:0];
         dec_mark = bits[FRAME_W-1];
         dec_perr = 1'b0;
      end else begin
         dec_data = {{(MP_W-NORM_W){1'b0}}, bits[NORM_W-1:0]};
         dec_mark = 1'b0;
         dec_perr = par_en & par_calc;
      end
   end

   // R5: multiprocessor frames never report a parity error
   p_mp_no_parity_r5: assert property (@(posedge clk) disable iff (!rst_n)
      mode_mp |-> !dec_perr);
endmodule

// File: rtl/async_rx_unit.sv
module async_rx_unit #(
   parameter int OVERSAMPLE  = 16,
   parameter int SYNC_STAGES = 2,
   parameter int NORM_W      = 7,
   parameter int MP_W        = 8,
   localparam int FRAME_W    = MP_W + 1,
   localparam int IDX_W      = $clog2(FRAME_W + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            rx_en,
   input  logic            mode_mp,
   input  logic            par_en,
   input  logic            par_odd,
   input  logic            irq_en,
   input  logic            samp_tick,
   input  logic            rxd,
   input  logic            rd_strobe,
   input  logic            err_clr,
   output logic [MP_W-1:0] rx_data,
   output logic            rx_mark,
   output logic            rx_full,
   output logic            err_parity,
   output logic            err_frame,
   output logic            err_overrun,
   output logic            rx_irq
);
   logic             line_s;
   logic             frame_start;
   logic             bit_vld;
   logic             bit_val;
   logic [IDX_W-1:0] bit_idx;
   logic             frame_done;
   logic             stop_val;
   logic [MP_W-1:0]  dec_data;
   logic             dec_mark;
   logic             dec_perr;

   rxu_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (rxd),
      .q    (line_s)
   );

   rxu_bit_timer #(
      .OVERSAMPLE(OVERSAMPLE),
      .NORM_W    (NORM_W),
      .MP_W      (MP_W)
   ) u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .rx_en      (rx_en),
      .tick       (samp_tick),
      .line       (line_s),
      .mode_mp    (mode_mp),
      .par_en     (par_en),
      .frame_start(frame_start),
      .bit_vld    (bit_vld),
      .bit_val    (bit_val),
      .bit_idx    (bit_idx),
      .frame_done (frame_done),
      .stop_val   (stop_val)
   );

   rxu_frame_asm #(
      .NORM_W(NORM_W),
      .MP_W  (MP_W)
   ) u_asm (
      .clk        (clk),
      .rst_n      (rst_n),
      .frame_start(frame_start),
      .bit_vld    (bit_vld),
      .bit_val    (bit_val),
      .bit_idx    (bit_idx),
      .mode_mp    (mode_mp),
      .par_en     (par_en),
      .par_odd    (par_odd),
      .dec_data   (dec_data),
      .dec_mark   (dec_mark),
      .dec_perr   (dec_perr)
   );

   logic ovr_hit;
   assign ovr_hit = frame_done & rx_full & ~rd_strobe;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_data     <= '0;
         rx_mark     <= 1'b0;
         rx_full     <= 1'b0;
         err_parity  <= 1'b0;
         err_frame   <= 1'b0;
         err_overrun <= 1'b0;
      end else begin
         if (frame_done) begin
            rx_data <= dec_data;
            rx_mark <= dec_mark;
         end
         rx_full     <= frame_done | (rx_full & ~rd_strobe);
         err_parity  <= (frame_done & dec_perr)  | (err_parity  & ~err_clr);
         err_frame   <= (frame_done & ~stop_val) | (err_frame   & ~err_clr);
         err_overrun <= ovr_hit                  | (err_overrun & ~err_clr);
      end
   end

   assign rx_irq = irq_en & rx_full;

   // R6: the full flag only rises after a completed frame
   p_full_from_frame_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_full) |-> $past(frame_done));

   // R7: a low stop sample raises the framing flag
   p_frame_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_done && !stop_val) |=> err_frame);

   // R8: completion over unread data raises the overrun flag
   p_overrun_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_done && rx_full && !rd_strobe) |=> (err_overrun && rx_full));

   // R9: a read with no new frame empties the register
   p_read_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_strobe && !frame_done) |=> !rx_full);

   // R10: error flags hold without a clear strobe
   p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ((err_parity || err_frame || err_overrun) && !err_clr) |=>
      ((err_parity  || !$past(err_parity)) &&
       (err_frame   || !$past(err_frame))  &&
       (err_overrun || !$past(err_overrun))));
endmodule

// File: tb/sim_async_rx_unit.sv
module sim_async_rx_unit;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rx_en = 1'b0;
   logic       mode_mp = 1'b0;
   logic       par_en = 1'b0;
   logic       par_odd = 1'b0;
   logic       irq_en = 1'b0;
   logic       samp_tick = 1'b0;
   logic       rxd = 1'b1;
   logic       rd_strobe = 1'b0;
   logic       err_clr = 1'b0;
   logic [7:0] rx_data;
   logic       rx_mark, rx_full, err_parity, err_frame, err_overrun, rx_irq;

   int checks = 0;
   int fails = 0;
   int tdiv = 1;
   int tcnt = 0;
   bit finished = 1'b0;

   async_rx_unit u0 (
      .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .mode_mp(mode_mp),
      .par_en(par_en), .par_odd(par_odd), .irq_en(irq_en),
      .samp_tick(samp_tick), .rxd(rxd), .rd_strobe(rd_strobe),
      .err_clr(err_clr), .rx_data(rx_data), .rx_mark(rx_mark),
      .rx_full(rx_full), .err_parity(err_parity), .err_frame(err_frame),
      .err_overrun(err_overrun), .rx_irq(rx_irq)
   );

   always #5 clk = ~clk;

   always @(negedge clk) begin
      if (tcnt >= tdiv - 1) begin
         samp_tick <= 1'b1;
         tcnt      <= 0;
      end else begin
         samp_tick <= 1'b0;
         tcnt      <= tcnt + 1;
      end
   end

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic hold_bit(input logic v);
      rxd = v;
      repeat (16 * tdiv) @(negedge clk);
   endtask

   task automatic send(input logic [9:0] bits, input int n, input logic stop);
      @(negedge clk);
      hold_bit(1'b0);
      for (int i = 0; i < n; i++) hold_bit(bits[i]);
      hold_bit(stop);
      hold_bit(1'b1);
      hold_bit(1'b1);
   endtask

   task automatic pulse_rd;
      @(negedge clk); rd_strobe = 1'b1;
      @(negedge clk); rd_strobe = 1'b0;
      @(negedge clk);
   endtask

   task automatic pulse_clr;
      @(negedge clk); err_clr = 1'b1;
      @(negedge clk); err_clr = 1'b0;
      @(negedge clk);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!finished) begin
         fails++;
         checks++;
         $display("FAIL watchdog actual=running expected=done");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      // R6: reset state
      chk("R6 reset full", rx_full, 0);
      chk("R6 reset data", rx_data, 0);
      chk("R6 reset mark", rx_mark, 0);
      chk("R6 reset errs", {err_parity, err_frame, err_overrun}, 0);
      chk("R11 reset irq", rx_irq, 0);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);

      // R1: disabled receiver ignores a frame
      send(10'h055, 7, 1'b1);
      chk("R1 disabled no full", rx_full, 0);

      rx_en  = 1'b1;
      irq_en = 1'b1;

      // R3: sweep of all normal-mode payloads without parity
      for (int v = 0; v < 128; v++) begin
         send(10'(v), 7, 1'b1);
         chk("R6 full set", rx_full, 1);
         chk("R3 data", rx_data, v);
         chk("R3 mark zero", rx_mark, 0);
         chk("R11 irq with full", rx_irq, 1);
         chk("R4 no parity err", err_parity, 0);
         pulse_rd();
         chk("R9 read clears", rx_full, 0);
         chk("R11 irq drops", rx_irq, 0);
      end

      // R4: parity in normal mode, both senses, good and bad
      par_en = 1'b1;
      for (int po = 0; po < 2; po++) begin
         par_odd = po[0];
         for (int v = 0; v < 128; v += 9) begin
            logic p;
            p = (^v[6:0]) ^ po[0];
            send({2'b0, p, v[6:0]}, 8, 1'b1);
            chk("R4 good parity data", rx_data, v);
            chk("R4 good parity flag", err_parity, 0);
            pulse_rd();
            send({2'b0, ~p, v[6:0]}, 8, 1'b1);
            chk("R4 bad parity flag", err_parity, 1);
            chk("R4 bad parity data", rx_data, v);
            pulse_rd();
            chk("R9 read keeps error", err_parity, 1);
            pulse_clr();
            chk("R10 clear parity", err_parity, 0);
         end
      end

      // R5: multiprocessor sweep over every byte
      mode_mp = 1'b1;
      for (int v = 0; v < 256; v++) begin
         logic mk;
         mk = v[0] ^ v[7] ^ v[3];
         send({1'b0, mk, v[7:0]}, 9, 1'b1);
         chk("R5 data", rx_data, v);
         chk("R5 mark", rx_mark, mk);
         chk("R5 no parity", err_parity, 0);
         pulse_rd();
      end

      // R12: slower sampling strobe
      tdiv = 3;
      repeat (8) @(negedge clk);
      for (int v = 0; v < 256; v += 37) begin
         send({1'b0, v[1], v[7:0]}, 9, 1'b1);
         chk("R12 slow data", rx_data, v);
         chk("R12 slow mark", rx_mark, v[1]);
         pulse_rd();
      end
      tdiv = 1;
      repeat (8) @(negedge clk);

      // R2: short low glitch is rejected
      @(negedge clk);
      rxd = 1'b0;
      repeat (4) @(negedge clk);
      rxd = 1'b1;
      repeat (400) @(negedge clk);
      chk("R2 glitch no full", rx_full, 0);
      chk("R2 glitch no frame err", err_frame, 0);

      // R1: enable dropped mid-frame abandons it
      mode_mp = 1'b0; par_en = 1'b0;
      @(negedge clk);
      hold_bit(1'b0);
      hold_bit(1'b0);
      hold_bit(1'b0);
      rx_en = 1'b0;
      repeat (4) @(negedge clk);
      rxd = 1'b1;
      rx_en = 1'b1;
      repeat (16 * 12) @(negedge clk);
      chk("R1 abandoned no full", rx_full, 0);

      // R7: low stop bit
      send(10'h2A, 7, 1'b0);
      chk("R7 frame err", err_frame, 1);
      chk("R7 data kept", rx_data, 8'h2A);
      chk("R7 full set", rx_full, 1);
      pulse_clr();
      chk("R10 clear frame err", err_frame, 0);
      chk("R10 clear keeps full", rx_full, 1);
      chk("R10 clear keeps data", rx_data, 8'h2A);
      pulse_rd();

      // R8: overrun
      send(10'h11, 7, 1'b1);
      chk("R8 no overrun first", err_overrun, 0);
      send(10'h6C, 7, 1'b1);
      chk("R8 overrun set", err_overrun, 1);
      chk("R8 data replaced", rx_data, 8'h6C);
      pulse_rd();
      chk("R9 read keeps overrun", err_overrun, 1);
      chk("R9 read clears full", rx_full, 0);
      pulse_clr();
      chk("R10 clear overrun", err_overrun, 0);

      // R11: interrupt masked
      irq_en = 1'b0;
      send(10'h33, 7, 1'b1);
      chk("R11 masked full", rx_full, 1);
      chk("R11 masked irq", rx_irq, 0);
      irq_en = 1'b1;
      @(negedge clk);
      chk("R11 unmasked irq", rx_irq, 1);
      pulse_rd();

      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule